// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits behind a write-through cache and takes stores off the processor's hands. A store is accepted in one cycle and the processor moves on without waiting for the memory write. Each slot in the buffer holds one block-aligned address, a block of data and a mask with one bit per byte. Every new store is compared against all held blocks. If its block is already present in a slot that is not being written out, the store's bytes are folded into that slot instead of taking a new one. A run of stores to one block therefore leaves as a single wide write.

Loads do not wait for the buffer to empty. A load presents a word address on a lookup port and gets back, in the same cycle, the buffered bytes of that word and a mask showing which bytes the buffer supplied. The caller fills the other bytes from memory. Slots leave through a valid/ready drain port, one block per handshake, oldest first. The slot at the front of the queue is locked while it is offered, so its contents stay fixed until memory accepts them.

Top module: `mwb_top`

## Requirements
- R1: After reset the drain port is idle (`dr_valid` low), `st_ready` is high and every load lookup returns a zero mask.
- R2: A store to a block held by no unlocked slot takes a new slot. That slot holds the block address and only the bytes enabled by `st_be`. Lane l of word w lands in byte w*WORD_BYTES+l of the block and sets the same bit of the block mask.
- R3: A store whose block is held by an unlocked slot is merged into that slot. Enabled bytes overwrite the older ones and set their mask bits. No new slot is taken, and the store is accepted even when every slot is in use.
- R4: Slots drain in the order they were taken. A merge leaves its slot's place in that order unchanged.
- R5: When all slots are in use and the store cannot merge, `st_ready` is low and the store is not taken. `st_ready` is high again in the cycle after a drain handshake.
- R6: The slot at the head of the queue is locked while offered on the drain port. A store to its block takes a new slot, and both slots drain separately.
- R7: A load lookup returns, for each byte lane, the byte from the youngest slot that holds that block with that byte's mask bit set. `ld_mask` bit l is set exactly for the lanes so supplied, and `ld_hit` is their OR.
- R8: While `dr_valid` is high and `dr_ready` is low, the drain address, data and mask hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_waddr | input | ADDR_W-log2(WORD_BYTES) | Store word address |
| st_data | input | WORD_BYTES*8 | Store data, lane l in bits 8l+7:8l |
| st_be | input | WORD_BYTES | Store byte enables |
| ld_waddr | input | ADDR_W-log2(WORD_BYTES) | Load lookup word address |
| ld_hit | output | 1 | At least one lane supplied by the buffer |
| ld_mask | output | WORD_BYTES | Lanes supplied by the buffer |
| ld_data | output | WORD_BYTES*8 | Buffered bytes for the supplied lanes |
| dr_valid | output | 1 | Head slot offered to memory |
| dr_ready | input | 1 | Memory accepts the offered slot |
| dr_baddr | output | ADDR_W-log2(BLOCK_BYTES) | Block address of the offered slot |
| dr_data | output | BLOCK_BYTES*8 | Block data of the offered slot |
| dr_mask | output | BLOCK_BYTES | Byte mask of the offered slot |

## Verification
The bound checker watches, on every cycle, that an offered block stays frozen until accepted, that a stall only happens with every slot in use, that a drain from a full buffer reopens the store port, that a merge never changes the occupancy, and that an empty buffer never claims load bytes. What those properties cannot show is where the data goes. Byte placement across all words and enable patterns, newest-byte-wins on lookups, the separate slot for a store to the locked head block, and the exact drain order after merges into older slots all come from the bench's directed sweep against a byte model.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;
   // Decision taken for the store presented this cycle
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_MERGE = 2'd1,
      ACT_ALLOC = 2'd2,
      ACT_STALL = 2'd3
   } st_act_e;
endpackage

// File: rtl/mwb_entry.sv
`timescale 1ns/1ps
module mwb_entry #(
   parameter  int unsigned BLOCK_BYTES = 32,
   parameter  int unsigned WORD_BYTES  = 4,
   parameter  int unsigned TAG_W       = 27,
   localparam int unsigned WIDX_W      = $clog2(BLOCK_BYTES / WORD_BYTES),
   localparam int unsigned WORD_BITS   = WORD_BYTES * 8,
   localparam int unsigned BLOCK_BITS  = BLOCK_BYTES * 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alloc_i,
   input  logic                   merge_i,
   input  logic                   release_i,
   input  logic [TAG_W-1:0]       tag_i,
   input  logic [WIDX_W-1:0]      widx_i,
   input  logic [WORD_BITS-1:0]   wdata_i,
   input  logic [WORD_BYTES-1:0]  wbe_i,
   output logic                   vld_o,
   output logic [TAG_W-1:0]       tag_o,
   output logic [BLOCK_BITS-1:0]  data_o,
   output logic [BLOCK_BYTES-1:0] mask_o
);
   logic [BLOCK_BYTES-1:0] byte_we;
   logic                   wr_any;

   assign wr_any = alloc_i | merge_i;

   // byte b of the block belongs to word b/WORD_BYTES, lane b%WORD_BYTES
   for (genvar b = 0; b < BLOCK_BYTES; b++) begin : g_byte
      assign byte_we[b] = (widx_i == WIDX_W'(b / WORD_BYTES)) && wbe_i[b % WORD_BYTES];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_o[b*8 +: 8] <= '0;
         end else if (wr_any && byte_we[b]) begin
            data_o[b*8 +: 8] <= wdata_i[(b % WORD_BYTES)*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         tag_o  <= '0;
         mask_o <= '0;
      end else if (release_i) begin
         vld_o  <= 1'b0;
         mask_o <= '0;
      end else if (alloc_i) begin
         vld_o  <= 1'b1;
         tag_o  <= tag_i;
         mask_o <= byte_we;
      end else if (merge_i) begin
         mask_o <= mask_o | byte_we;
      end
   end
endmodule

// File: rtl/mwb_match.sv
`timescale 1ns/1ps
module mwb_match #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned TAG_W = 27
) (
   input  logic [DEPTH-1:0]            vld_i,
   input  logic [DEPTH-1:0]            elig_i,
   input  logic [DEPTH-1:0][TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]            key_i,
   output logic [DEPTH-1:0]            hit_o
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit_o[i] = vld_i[i] && elig_i[i] && (tags_i[i] == key_i);
   end
endmodule

// File: rtl/mwb_load_sel.sv
`timescale 1ns/1ps
module mwb_load_sel #(
   parameter  int unsigned DEPTH       = 4,
   parameter  int unsigned BLOCK_BYTES = 32,
   parameter  int unsigned WORD_BYTES  = 4,
   parameter  int unsigned TAG_W       = 27,
   localparam int unsigned PTR_W       = $clog2(DEPTH),
   localparam int unsigned WIDX_W      = $clog2(BLOCK_BYTES / WORD_BYTES),
   localparam int unsigned WORD_BITS   = WORD_BYTES * 8,
   localparam int unsigned BLOCK_BITS  = BLOCK_BYTES * 8
) (
   input  logic [DEPTH-1:0]                  vld_i,
   input  logic [DEPTH-1:0][TAG_W-1:0]       tags_i,
   input  logic [DEPTH-1:0][BLOCK_BITS-1:0]  data_i,
   input  logic [DEPTH-1:0][BLOCK_BYTES-1:0] mask_i,
   input  logic [PTR_W-1:0]                  head_i,
   input  logic [TAG_W-1:0]                  key_tag_i,
   input  logic [WIDX_W-1:0]                 key_widx_i,
   output logic [WORD_BYTES-1:0]             mask_o,
   output logic [WORD_BITS-1:0]              data_o
);
   logic [DEPTH-1:0] hit;

   mwb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cmp (
      .vld_i  (vld_i),
      .elig_i ({DEPTH{1'b1}}),
      .tags_i (tags_i),
      .key_i  (key_tag_i),
      .hit_o  (hit)
   );

   // walk slots oldest to youngest so younger bytes overwrite older ones
   always_comb begin
      logic [PTR_W-1:0] idx;
      int unsigned      bi;
      mask_o = '0;
      data_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head_i + PTR_W'(k);
         for (int l = 0; l < WORD_BYTES; l++) begin
            bi = int'(key_widx_i) * WORD_BYTES + l;
            if (hit[idx] && mask_i[idx][bi]) begin
               mask_o[l]        = 1'b1;
               data_o[l*8 +: 8] = data_i[idx][bi*8 +: 8];
            end
         end
      end
   end
endmodule

// File: rtl/mwb_top.sv
`timescale 1ns/1ps
module mwb_top #(
   parameter  int unsigned ADDR_W      = 32,
   parameter  int unsigned DEPTH       = 4,
   parameter  int unsigned BLOCK_BYTES = 32,
   parameter  int unsigned WORD_BYTES  = 4,
   localparam int unsigned LANE_W      = $clog2(WORD_BYTES),
   localparam int unsigned OFF_W       = $clog2(BLOCK_BYTES),
   localparam int unsigned WA_W        = ADDR_W - LANE_W,
   localparam int unsigned TAG_W       = ADDR_W - OFF_W,
   localparam int unsigned WIDX_W      = OFF_W - LANE_W,
   localparam int unsigned PTR_W       = $clog2(DEPTH),
   localparam int unsigned CNT_W       = $clog2(DEPTH + 1),
   localparam int unsigned WORD_BITS   = WORD_BYTES * 8,
   localparam int unsigned BLOCK_BITS  = BLOCK_BYTES * 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   st_valid,
   output logic                   st_ready,
   input  logic [WA_W-1:0]        st_waddr,
   input  logic [WORD_BITS-1:0]   st_data,
   input  logic [WORD_BYTES-1:0]  st_be,
   input  logic [WA_W-1:0]        ld_waddr,
   output logic                   ld_hit,
   output logic [WORD_BYTES-1:0]  ld_mask,
   output logic [WORD_BITS-1:0]   ld_data,
   output logic                   dr_valid,
   input  logic                   dr_ready,
   output logic [TAG_W-1:0]       dr_baddr,
   output logic [BLOCK_BITS-1:0]  dr_data,
   output logic [BLOCK_BYTES-1:0] dr_mask
);
   import mwb_pkg::*;

   initial begin : param_chk
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "DEPTH must be a power of two, at least 2");
      if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0)
         $fatal(1, "WORD_BYTES must be a power of two, at least 2");
      if (BLOCK_BYTES <= WORD_BYTES || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0)
         $fatal(1, "BLOCK_BYTES must be a power of two above WORD_BYTES");
      if (ADDR_W <= OFF_W)
         $fatal(1, "ADDR_W too small for the block size");
   end

   logic [DEPTH-1:0]                  e_vld;
   logic [DEPTH-1:0][TAG_W-1:0]       e_tag;
   logic [DEPTH-1:0][BLOCK_BITS-1:0]  e_data;
   logic [DEPTH-1:0][BLOCK_BYTES-1:0] e_mask;
   logic [DEPTH-1:0]                  e_lock;
   logic [DEPTH-1:0]                  st_hit;

   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;

   logic [TAG_W-1:0]  st_tag;
   logic [WIDX_W-1:0] st_widx;
   logic              st_merge, full, dr_fire, do_alloc;
   st_act_e           st_act;

   assign st_tag   = st_waddr[WA_W-1:WIDX_W];
   assign st_widx  = st_waddr[WIDX_W-1:0];
   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign dr_valid = (cnt_q != '0);
   assign dr_fire  = dr_valid && dr_ready;

   // head slot is frozen while it sits on the drain port
   for (genvar i = 0; i < DEPTH; i++) begin : g_lock
      assign e_lock[i] = dr_valid && (head_q == PTR_W'(i));
   end

   mwb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_st_cmp (
      .vld_i  (e_vld),
      .elig_i (~e_lock),
      .tags_i (e_tag),
      .key_i  (st_tag),
      .hit_o  (st_hit)
   );

   assign st_merge = |st_hit;

   always_comb begin
      if (!st_valid)      st_act = ACT_NONE;
      else if (st_merge)  st_act = ACT_MERGE;
      else if (!full)     st_act = ACT_ALLOC;
      else                st_act = ACT_STALL;
   end

   assign st_ready = st_merge || !full;
   assign do_alloc = (st_act == ACT_ALLOC);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      mwb_entry #(
         .BLOCK_BYTES (BLOCK_BYTES),
         .WORD_BYTES  (WORD_BYTES),
         .TAG_W       (TAG_W)
      ) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_i   (do_alloc && (tail_q == PTR_W'(i))),
         .merge_i   ((st_act == ACT_MERGE) && st_hit[i]),
         .release_i (dr_fire && (head_q == PTR_W'(i))),
         .tag_i     (st_tag),
         .widx_i    (st_widx),
         .wdata_i   (st_data),
         .wbe_i     (st_be),
         .vld_o     (e_vld[i]),
         .tag_o     (e_tag[i]),
         .data_o    (e_data[i]),
         .mask_o    (e_mask[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_alloc) tail_q <= tail_q + 1'b1;
         if (dr_fire)  head_q <= head_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(do_alloc) - CNT_W'(dr_fire);
      end
   end

   assign dr_baddr = e_tag[head_q];
   assign dr_data  = e_data[head_q];
   assign dr_mask  = e_mask[head_q];

   mwb_load_sel #(
      .DEPTH       (DEPTH),
      .BLOCK_BYTES (BLOCK_BYTES),
      .WORD_BYTES  (WORD_BYTES),
      .TAG_W       (TAG_W)
   ) u_ld (
      .vld_i      (e_vld),
      .tags_i     (e_tag),
      .data_i     (e_data),
      .mask_i     (e_mask),
      .head_i     (head_q),
      .key_tag_i  (ld_waddr[WA_W-1:WIDX_W]),
      .key_widx_i (ld_waddr[WIDX_W-1:0]),
      .mask_o     (ld_mask),
      .data_o     (ld_data)
   );

   assign ld_hit = |ld_mask;
endmodule

// File: rtl/mwb_chk.sv
`timescale 1ns/1ps
module mwb_chk #(
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned BLOCK_BYTES = 32,
   parameter int unsigned WORD_BYTES  = 4,
   parameter int unsigned TAG_W       = 27,
   parameter int unsigned CNT_W       = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   st_valid,
   input logic                   st_ready,
   input logic                   st_merge,
   input logic                   dr_valid,
   input logic                   dr_ready,
   input logic [TAG_W-1:0]       dr_baddr,
   input logic [BLOCK_BYTES*8-1:0] dr_data,
   input logic [BLOCK_BYTES-1:0] dr_mask,
   input logic [WORD_BYTES-1:0]  ld_mask,
   input logic [CNT_W-1:0]       cnt_q
);
   // R8
   drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dr_valid && !dr_ready |=> dr_valid && $stable(dr_baddr) && $stable(dr_data) && $stable(dr_mask));

   // R2
   alloc_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && st_ready && !dr_valid |=> dr_valid);

   // R5
   stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_ready |-> cnt_q == CNT_W'(DEPTH));

   // R5
   reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dr_valid && dr_ready && cnt_q == CNT_W'(DEPTH) |=> st_ready);

   // R3
   merge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && st_ready && st_merge && !(dr_valid && dr_ready) |=> cnt_q == $past(cnt_q));

   // R7
   empty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dr_valid |-> ld_mask == '0);
endmodule

bind mwb_top mwb_chk #(
   .DEPTH       (DEPTH),
   .BLOCK_BYTES (BLOCK_BYTES),
   .WORD_BYTES  (WORD_BYTES),
   .TAG_W       (TAG_W),
   .CNT_W       (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st_valid (st_valid),
   .st_ready (st_ready),
   .st_merge (st_merge),
   .dr_valid (dr_valid),
   .dr_ready (dr_ready),
   .dr_baddr (dr_baddr),
   .dr_data  (dr_data),
   .dr_mask  (dr_mask),
   .ld_mask  (ld_mask),
   .cnt_q    (cnt_q)
);

// File: tb/sim_mwb_top.sv
`timescale 1ns/1ps
module sim_mwb_top;
   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         st_valid;
   logic         st_ready;
   logic [29:0]  st_waddr;
   logic [31:0]  st_data;
   logic [3:0]   st_be;
   logic [29:0]  ld_waddr;
   logic         ld_hit;
   logic [3:0]   ld_mask;
   logic [31:0]  ld_data;
   logic         dr_valid;
   logic         dr_ready;
   logic [26:0]  dr_baddr;
   logic [255:0] dr_data;
   logic [31:0]  dr_mask;

   int  n_vec  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   localparam logic [26:0] B0 = 27'h10;
   localparam logic [26:0] B1 = 27'h11;
   localparam logic [26:0] B2 = 27'h25;
   localparam logic [26:0] B3 = 27'h3A;

   logic [255:0] m1_data;
   logic [31:0]  m1_mask;

   always #(CLK_P/2) clk = ~clk;

   mwb_top #(.ADDR_W(32), .DEPTH(4), .BLOCK_BYTES(32), .WORD_BYTES(4)) u0 (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_waddr(st_waddr),
      .st_data(st_data), .st_be(st_be),
      .ld_waddr(ld_waddr), .ld_hit(ld_hit), .ld_mask(ld_mask), .ld_data(ld_data),
      .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_baddr(dr_baddr),
      .dr_data(dr_data), .dr_mask(dr_mask)
   );

   task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] wdat(int w, int be);
      logic [31:0] d;
      for (int l = 0; l < 4; l++) d[l*8 +: 8] = 8'(w*37 + be*5 + l + 1);
      return d;
   endfunction

   function automatic logic [31:0] lane_bits(logic [3:0] m);
      logic [31:0] r;
      for (int l = 0; l < 4; l++) r[l*8 +: 8] = {8{m[l]}};
      return r;
   endfunction

   // store: drive at a falling edge, held for one rising edge
   task automatic do_store(string req, logic [26:0] tag, int w, logic [31:0] d, logic [3:0] be);
      st_valid = 1'b1;
      st_waddr = {tag, 3'(w)};
      st_data  = d;
      st_be    = be;
      #1;
      chk(req, 256'(st_ready), 256'(1));
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic ld_check(string req, logic [26:0] tag, int w, logic [3:0] em, logic [31:0] ed);
      ld_waddr = {tag, 3'(w)};
      #1;
      chk(req, 256'(ld_mask), 256'(em));
      chk(req, 256'(ld_data & lane_bits(em)), 256'(ed & lane_bits(em)));
   endtask

   task automatic drain_expect(string req, logic [26:0] tag, logic [31:0] m, logic [255:0] d);
      #1;
      chk(req, 256'(dr_valid), 256'(1));
      chk(req, 256'(dr_baddr), 256'(tag));
      chk(req, 256'(dr_mask), 256'(m));
      for (int b = 0; b < 32; b++)
         if (m[b]) chk(req, 256'(dr_data[b*8 +: 8]), 256'(d[b*8 +: 8]));
      dr_ready = 1'b1;
      @(negedge clk);
      dr_ready = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=hung exp=done");
         finish_run();
      end
   end

   initial begin : stim
      logic [255:0] b0_first, b0_second, b2_d, b3_d;
      rst_n    = 1'b0;
      st_valid = 1'b0;
      st_waddr = '0;
      st_data  = '0;
      st_be    = '0;
      ld_waddr = '0;
      dr_ready = 1'b0;
      m1_data  = '0;
      m1_mask  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", 256'(dr_valid), 256'(0));
      chk("R1", 256'(st_ready), 256'(1));
      ld_check("R1", B1, 0, 4'h0, 32'h0);

      // R2 first store takes a slot and is offered
      @(negedge clk);
      do_store("R2", B0, 0, 32'h0000_00AA, 4'b0001);
      #1;
      chk("R2", 256'(dr_valid), 256'(1));
      chk("R2", 256'(dr_baddr), 256'(B0));
      chk("R2", 256'(dr_mask), 256'(32'h1));
      chk("R2", 256'(dr_data[7:0]), 256'(8'hAA));
      b0_first = 256'(8'hAA);

      // R2 R3 R7 sweep every word and enable pattern into one block
      for (int w = 0; w < 8; w++) begin
         for (int be = 1; be < 16; be++) begin
            logic [31:0] d;
            d = wdat(w, be);
            do_store("R3", B1, w, d, 4'(be));
            for (int l = 0; l < 4; l++)
               if (be[l]) begin
                  m1_data[(w*4+l)*8 +: 8] = d[l*8 +: 8];
                  m1_mask[w*4+l] = 1'b1;
               end
            ld_check("R7", B1, w, m1_mask[w*4 +: 4], m1_data[w*32 +: 32]);
            chk("R4", 256'(dr_baddr), 256'(B0));
         end
      end

      // R6 store to locked head block takes its own slot; R7 newest bytes win
      do_store("R6", B0, 0, 32'h0000_BBCC, 4'b0011);
      b0_second = 256'(16'hBBCC);
      ld_check("R7", B0, 0, 4'b0011, 32'h0000_BBCC);
      chk("R6", 256'(dr_mask), 256'(32'h1));

      // fourth slot
      b2_d = '0;
      b2_d[5*32 +: 32] = wdat(5, 15);
      do_store("R2", B2, 5, wdat(5, 15), 4'hF);

      // R3 merge accepted while full, into an older slot
      do_store("R3", B1, 2, 32'h005A_0000, 4'b0100);
      m1_data[(2*4+2)*8 +: 8] = 8'h5A;

      // R5 non-merging store stalls
      st_valid = 1'b1;
      st_waddr = {B3, 3'd1};
      st_data  = 32'hC0DE_F00D;
      st_be    = 4'hF;
      #1;
      chk("R5", 256'(st_ready), 256'(0));
      @(negedge clk);
      chk("R5", 256'(st_ready), 256'(0));
      ld_check("R5", B3, 1, 4'h0, 32'h0);

      // R4 drain order with the store still held
      drain_expect("R4", B0, 32'h1, b0_first);
      #1;
      chk("R5", 256'(st_ready), 256'(1));
      @(negedge clk);
      st_valid = 1'b0;
      b3_d = '0;
      b3_d[1*32 +: 32] = 32'hC0DE_F00D;

      drain_expect("R4", B1, 32'hFFFF_FFFF, m1_data);
      drain_expect("R6", B0, 32'h3, b0_second);
      drain_expect("R4", B2, 32'h00F0_0000, b2_d);
      drain_expect("R4", B3, 32'h0000_00F0, b3_d);

      #1;
      chk("R1", 256'(dr_valid), 256'(0));
      chk("R5", 256'(st_ready), 256'(1));
      ld_check("R7", B1, 2, 4'h0, 32'h0);

      done = 1;
      finish_run();
   end
endmodule